// File: doc/BRIEF.md
# Bidirectional codec host FIFO bridge

This block sits between a compression engine and a host bus whose accesses complete on an active-low acknowledge. It holds a 16-bit wide, 32-entry data FIFO whose direction is picked by a mode input. In encode mode the engine pushes compressed words, each tagged with an end-of-field marker, and the host pulls them out with read accesses. In decode mode the host pushes compressed words with write accesses and the engine drains them through a valid/ready output stage.

The host holds a request, with its direction and write data steady, until it sees the acknowledge go low, and then drops the request. Every access spends at least one wait cycle with the acknowledge high. When the FIFO cannot serve an access (a decode write while full, or an encode read while empty), the acknowledge stays high until it can. A service-request flag tells the host when to come back: in encode it rises once the stored word count reaches a programmable nearly-full level, and in decode it stays high while the count is at or below a programmable nearly-empty level. A last-code flag warns the host that the next read returns the final word of a field. A soft clear input empties the FIFO without a full reset.

Top module: `codec_host_fifo_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous active-low reset), all state returns to reset: `host_ack_n` high, `srq` low, `last_code` low, `eng_out_valid` low, FIFO empty.
- R2: When `host_req` rises, `host_ack_n` stays high for the first clock edge that samples it; a serviceable access drives `host_ack_n` low at the second edge, holds it low while `host_req` stays high, and returns it high at the first edge that sees `host_req` low.
- R3: In encode mode (`mode`=0), host reads return the words the engine pushed, in push order, on `host_rdata` while `host_ack_n` is low.
- R4: In encode mode, a host read from an empty FIFO keeps `host_ack_n` high until the engine pushes a word, then completes with that word.
- R5: In decode mode (`mode`=1), host-written words reach `eng_out_data` in write order; `eng_out_data` stays steady while `eng_out_valid` is high and `eng_out_ready` is low.
- R6: In decode mode, the bridge holds 33 words (32 in the FIFO plus one in the engine output stage); a further host write keeps `host_ack_n` high until the engine takes a word.
- R7: In encode mode, `srq` is high one clock after the stored word count is at or above `nf_level`, and low otherwise.
- R8: In decode mode, `srq` is high one clock after the FIFO count (excluding the word held in the engine output stage) is at or below `ne_level`, and low otherwise; after a soft clear it is therefore high.
- R9: In encode mode, `last_code` is high, one clock after the FIFO head changes, exactly when the word the next host read returns was pushed with `eng_in_eof`=1.
- R10: An access against the mode's direction completes with the normal timing but touches no data: an encode-mode write stores nothing, and a decode-mode read returns zero and consumes nothing.
- R11: `soft_clr` high at a clock edge empties the FIFO and the engine output stage and returns the host handshake to idle.
- R12: In encode mode, `eng_in_ready` is high exactly when the FIFO holds fewer than 32 words; in decode mode it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Synchronous FIFO clear |
| mode | input | 1 | 0 = encode (engine to host), 1 = decode (host to engine) |
| nf_level | input | 6 | Nearly-full level for encode service request |
| ne_level | input | 6 | Nearly-empty level for decode service request |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid while acknowledge low |
| host_ack_n | output | 1 | Active-low access acknowledge |
| eng_in_valid | input | 1 | Engine word valid (encode) |
| eng_in_data | input | 16 | Engine word (encode) |
| eng_in_eof | input | 1 | Engine word is last of field (encode) |
| eng_in_ready | output | 1 | Bridge accepts engine word |
| eng_out_valid | output | 1 | Word available to engine (decode) |
| eng_out_data | output | 16 | Word to engine (decode) |
| eng_out_ready | input | 1 | Engine takes the word |
| srq | output | 1 | Service request |
| last_code | output | 1 | Next host read returns last word of field |

## Verification
Checked on every cycle: no push into a full FIFO and no pop from an empty one, no acknowledge straight out of idle, a held-high acknowledge for a decode write against a full FIFO, release of the acknowledge once the request drops, a steady engine output word under back-pressure, a high decode service request whenever the FIFO is empty, and a last-code flag only over a non-empty FIFO. Only the bench scenarios show the data order in both directions, the exact threshold crossings of the service request across every fill level for several programmed levels, the last-code flag landing on the right word, the stall-then-complete behaviour of reads from empty, and the no-effect behaviour of wrong-direction accesses and soft clear.

// File: rtl/codec_fifo_pkg.sv
package codec_fifo_pkg;

  typedef enum logic [1:0] {
    HP_IDLE = 2'd0,
    HP_WAIT = 2'd1,
    HP_ACK  = 2'd2
  } hp_state_t;

  localparam logic MODE_ENC = 1'b0;
  localparam logic MODE_DEC = 1'b1;

endpackage

// File: rtl/cfb_store.sv
module cfb_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_eof,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          head_eof,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] eof_bits;
  logic [AW-1:0]    wp;
  logic [AW-1:0]    rp;

  // Data array: one write port, one registered read port (block RAM style).
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
    if (rd_en) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      eof_bits <= '0;
    end else begin
      if (wr_en) begin
        wp           <= wp + AW'(1);
        eof_bits[wp] <= wr_eof;
      end
      if (rd_en) rp <= rp + AW'(1);
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign head_eof = eof_bits[rp];

  // R6: the FIFO never accepts a word when full
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_en);

  // R4: the FIFO never releases a word when empty
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !rd_en);

endmodule

// File: rtl/cfb_host_port.sv
module cfb_host_port
  import codec_fifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic mode,
  input  logic req,
  input  logic wr,
  input  logic full,
  input  logic empty,
  output logic ack_n,
  output logic push,
  output logic pop
);

  hp_state_t st, st_n;

  always_comb begin
    st_n = st;
    push = 1'b0;
    pop  = 1'b0;
    case (st)
      HP_IDLE: if (req) st_n = HP_WAIT;
      HP_WAIT: begin
        if (wr) begin
          if (mode == MODE_DEC) begin
            if (!full) begin
              push = 1'b1;
              st_n = HP_ACK;
            end
          end else begin
            st_n = HP_ACK;
          end
        end else begin
          if (mode == MODE_ENC) begin
            if (!empty) begin
              pop  = 1'b1;
              st_n = HP_ACK;
            end
          end else begin
            st_n = HP_ACK;
          end
        end
      end
      HP_ACK:  if (!req) st_n = HP_IDLE;
      default: st_n = HP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st    <= HP_IDLE;
      ack_n <= 1'b1;
    end else begin
      st    <= st_n;
      ack_n <= (st_n != HP_ACK);
    end
  end

  // R2: an idle cycle is always followed by a high acknowledge (wait cycle)
  a_r2_wait_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HP_IDLE) |=> ack_n);

  // R2: a dropped request releases the acknowledge
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HP_ACK && !req) |=> ack_n);

  // R6: a decode write facing a full FIFO keeps the acknowledge high
  a_r6_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HP_WAIT && wr && mode == MODE_DEC && full) |=> ack_n);

endmodule

// File: rtl/cfb_flags.sv
module cfb_flags
  import codec_fifo_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          mode,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] nf_level,
  input  logic [CW-1:0] ne_level,
  input  logic          head_eof,
  output logic          srq,
  output logic          last_code
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srq       <= 1'b0;
      last_code <= 1'b0;
    end else begin
      if (mode == MODE_ENC) srq <= (count >= nf_level);
      else                  srq <= (count <= ne_level);
      last_code <= (mode == MODE_ENC) && (count != '0) && head_eof;
    end
  end

  // R8: an empty decode FIFO always requests service on the next cycle
  a_r8_empty_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DEC && count == '0 && !clr) |=> srq);

  // R9: last_code only ever reflects a non-empty FIFO
  a_r9_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    last_code |-> $past(count) != '0);

endmodule

// File: rtl/codec_host_fifo_bridge.sv
module codec_host_fifo_bridge
  import codec_fifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          mode,
  input  logic [CW-1:0] nf_level,
  input  logic [CW-1:0] ne_level,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_ack_n,
  input  logic          eng_in_valid,
  input  logic [DW-1:0] eng_in_data,
  input  logic          eng_in_eof,
  output logic          eng_in_ready,
  output logic          eng_out_valid,
  output logic [DW-1:0] eng_out_data,
  input  logic          eng_out_ready,
  output logic          srq,
  output logic          last_code
);

  logic          full, empty, head_eof;
  logic [CW-1:0] count;
  logic [DW-1:0] rd_q;
  logic          h_push, h_pop, e_push, e_pop;
  logic          wr_en, rd_en, wr_eof;
  logic [DW-1:0] wr_data;
  logic          out_vld;

  // Engine side handshakes
  assign eng_in_ready = (mode == MODE_ENC) && !full;
  assign e_push       = eng_in_valid && eng_in_ready;
  assign e_pop        = (mode == MODE_DEC) && !empty && (!out_vld || eng_out_ready);

  // Single write port and single read port, shared by direction
  assign wr_en   = h_push | e_push;
  assign wr_data = (mode == MODE_DEC) ? host_wdata : eng_in_data;
  assign wr_eof  = (mode == MODE_ENC) && eng_in_eof;
  assign rd_en   = h_pop | e_pop;

  cfb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_clr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_eof   (wr_eof),
    .rd_en    (rd_en),
    .rd_data  (rd_q),
    .count    (count),
    .head_eof (head_eof),
    .full     (full),
    .empty    (empty)
  );

  cfb_host_port u_host (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (soft_clr),
    .mode  (mode),
    .req   (host_req),
    .wr    (host_wr),
    .full  (full),
    .empty (empty),
    .ack_n (host_ack_n),
    .push  (h_push),
    .pop   (h_pop)
  );

  cfb_flags #(.CW(CW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_clr),
    .mode      (mode),
    .count     (count),
    .nf_level  (nf_level),
    .ne_level  (ne_level),
    .head_eof  (head_eof),
    .srq       (srq),
    .last_code (last_code)
  );

  // Engine output stage: the RAM read register doubles as the output data
  always_ff @(posedge clk) begin
    if (!rst_n || soft_clr) out_vld <= 1'b0;
    else if (e_pop)         out_vld <= 1'b1;
    else if (eng_out_ready) out_vld <= 1'b0;
  end

  assign eng_out_valid = out_vld;
  assign eng_out_data  = rd_q;
  assign host_rdata    = (mode == MODE_ENC) ? rd_q : '0;

  // R5: a stalled engine output keeps its word
  a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !eng_out_ready && !soft_clr) |=> (out_vld && $stable(eng_out_data)));

endmodule

// File: tb/test_codec_host_fifo_bridge.sv
module test_codec_host_fifo_bridge;
  localparam int DW = 16;
  localparam int DEPTH = 32;
  localparam int CW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, soft_clr, mode;
  logic [CW-1:0] nf_level, ne_level;
  logic          host_req, host_wr;
  logic [DW-1:0] host_wdata, host_rdata;
  logic          host_ack_n;
  logic          eng_in_valid, eng_in_eof, eng_in_ready;
  logic [DW-1:0] eng_in_data;
  logic          eng_out_valid, eng_out_ready;
  logic [DW-1:0] eng_out_data;
  logic          srq, last_code;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  codec_host_fifo_bridge #(.DW(DW), .DEPTH(DEPTH)) i_codec_host_fifo_bridge (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .mode(mode),
    .nf_level(nf_level), .ne_level(ne_level),
    .host_req(host_req), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ack_n(host_ack_n),
    .eng_in_valid(eng_in_valid), .eng_in_data(eng_in_data), .eng_in_eof(eng_in_eof),
    .eng_in_ready(eng_in_ready), .eng_out_valid(eng_out_valid),
    .eng_out_data(eng_out_data), .eng_out_ready(eng_out_ready),
    .srq(srq), .last_code(last_code)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clr();
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
    settle();
  endtask

  // Full host access with R2 timing checks; starts and ends at a falling edge.
  task automatic host_access(input logic wr, input logic [DW-1:0] wd,
                             input bit fast, output logic [DW-1:0] rd);
    int n;
    host_wr = wr;
    host_wdata = wd;
    host_req = 1'b1;
    @(negedge clk);
    chk("R2 wait cycle ack_n", host_ack_n, 1);
    n = 1;
    while (host_ack_n) begin
      @(negedge clk);
      n++;
    end
    if (fast) chk("R2 ack latency", n, 2);
    rd = host_rdata;
    @(negedge clk);
    chk("R2 ack held while req", host_ack_n, 0);
    host_req = 1'b0;
    @(negedge clk);
    chk("R2 ack released", host_ack_n, 1);
  endtask

  task automatic eng_push(input logic [DW-1:0] d, input logic eof);
    chk("R12 ready before push", eng_in_ready, 1);
    eng_in_valid = 1'b1;
    eng_in_data = d;
    eng_in_eof = eof;
    @(negedge clk);
    eng_in_valid = 1'b0;
    eng_in_eof = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] rd;
    int thr [3] = '{0, 4, 31};
    int nel [2] = '{0, 5};
    int got;

    rst_n = 1'b0; soft_clr = 1'b0; mode = 1'b0;
    nf_level = 6'd4; ne_level = 6'd0;
    host_req = 1'b0; host_wr = 1'b0; host_wdata = '0;
    eng_in_valid = 1'b0; eng_in_data = '0; eng_in_eof = 1'b0;
    eng_out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ack_n after reset", host_ack_n, 1);
    chk("R1 srq after reset", srq, 0);
    chk("R1 last_code after reset", last_code, 0);
    chk("R1 eng_out_valid after reset", eng_out_valid, 0);
    chk("R1 eng_in_ready after reset (empty)", eng_in_ready, 1);

    // Encode: fill and drain for several nearly-full levels (R3 R7 R9 R12)
    foreach (thr[ti]) begin
      mode = 1'b0;
      nf_level = CW'(thr[ti]);
      pulse_clr();
      for (int k = 0; k <= 32; k++) begin
        settle();
        chk("R7 srq encode fill", srq, (k >= thr[ti]));
        chk("R12 eng_in_ready level", eng_in_ready, (k < 32));
        if (k < 32) eng_push(16'hA000 + DW'(ti * 256 + k), (k == 9 || k == 31));
      end
      for (int k = 0; k < 32; k++) begin
        chk("R9 last_code before read", last_code, (k == 9 || k == 31));
        host_access(1'b0, '0, 1, rd);
        chk("R3 encode read order", rd, 16'hA000 + DW'(ti * 256 + k));
        settle();
        chk("R7 srq encode drain", srq, ((31 - k) >= thr[ti]));
      end
    end

    // R4: read from empty stalls until the engine pushes
    mode = 1'b0; nf_level = 6'd4;
    pulse_clr();
    host_wr = 1'b0; host_req = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk("R4 ack held on empty read", host_ack_n, 1);
    end
    eng_push(16'h5A5A, 1'b0);
    while (host_ack_n) @(negedge clk);
    chk("R4 stalled read data", host_rdata, 16'h5A5A);
    @(negedge clk);
    host_req = 1'b0;
    @(negedge clk);
    chk("R4 ack released", host_ack_n, 1);

    // R10: wrong-direction accesses
    nf_level = 6'd1;
    pulse_clr();
    host_access(1'b1, 16'h1234, 1, rd);
    settle();
    chk("R10 encode write stores nothing (srq)", srq, 0);
    chk("R10 encode write stores nothing (ready)", eng_in_ready, 1);
    mode = 1'b1; ne_level = 6'd0; eng_out_ready = 1'b0;
    pulse_clr();
    host_access(1'b1, 16'h7777, 1, rd);
    settle();
    chk("R5 word at engine output", eng_out_valid, 1);
    host_access(1'b0, '0, 1, rd);
    chk("R10 decode read returns zero", rd, 0);
    settle();
    chk("R10 decode read consumes nothing (valid)", eng_out_valid, 1);
    chk("R10 decode read consumes nothing (data)", eng_out_data, 16'h7777);

    // Decode: fill to capacity, stall, drain for two nearly-empty levels (R5 R6 R8)
    foreach (nel[ni]) begin
      mode = 1'b1;
      ne_level = CW'(nel[ni]);
      eng_out_ready = 1'b0;
      pulse_clr();
      chk("R8 srq high after soft clear", srq, 1);
      for (int k = 1; k <= 33; k++) begin
        host_access(1'b1, 16'hC000 + DW'(ni * 256 + k - 1), 1, rd);
        settle();
        chk("R8 srq decode fill", srq, ((k - 1) <= nel[ni]));
        chk("R5 eng_out_valid while holding", eng_out_valid, 1);
      end
      host_wr = 1'b1; host_wdata = 16'hC000 + DW'(ni * 256 + 33); host_req = 1'b1;
      repeat (5) begin
        @(negedge clk);
        chk("R6 ack held on full write", host_ack_n, 1);
      end
      chk("R5 first word at output", eng_out_data, 16'hC000 + DW'(ni * 256));
      eng_out_ready = 1'b1;
      @(negedge clk);
      eng_out_ready = 1'b0;
      while (host_ack_n) @(negedge clk);
      @(negedge clk);
      host_req = 1'b0;
      @(negedge clk);
      chk("R6 ack released after full write", host_ack_n, 1);
      got = 1;
      eng_out_ready = 1'b1;
      while (got < 34) begin
        if (eng_out_valid) begin
          chk("R5 decode output order", eng_out_data, 16'hC000 + DW'(ni * 256 + got));
          got++;
        end
        @(negedge clk);
      end
      eng_out_ready = 1'b0;
      settle();
      chk("R5 output empty after drain", eng_out_valid, 0);
      chk("R8 srq high when drained", srq, 1);
    end

    // R11: soft clear empties both directions
    mode = 1'b1; ne_level = 6'd0;
    pulse_clr();
    for (int k = 0; k < 4; k++) host_access(1'b1, DW'(k), 1, rd);
    settle();
    chk("R8 srq low with data", srq, 0);
    pulse_clr();
    chk("R11 engine output cleared", eng_out_valid, 0);
    chk("R11 decode srq after clear", srq, 1);
    mode = 1'b0; nf_level = 6'd3;
    pulse_clr();
    for (int k = 0; k < 5; k++) eng_push(DW'(k), 1'b1);
    settle();
    chk("R9 last_code on eof head", last_code, 1);
    chk("R7 srq at level", srq, 1);
    pulse_clr();
    chk("R11 last_code after clear", last_code, 0);
    chk("R11 encode srq after clear", srq, 0);
    chk("R11 ready after clear", eng_in_ready, 1);
    mode = 1'b1;
    settle();
    chk("R12 ready low in decode", eng_in_ready, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule